// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers interrupt requests for a small 8-bit processor core and presents them as one interrupt line with a source number. Fifteen sources feed it. Thirteen are one-cycle event pulses from on-chip peripherals. The other two come from external pins, and each pin has its own selectable edge polarity. Every detected event latches a request bit. Only hardware sets a request bit, and only software or the acknowledge clears it.

Software reaches the block through a byte-wide register port with an address, write data, a write strobe and a combinational read-data return. It can read the pending requests, clear them by writing zeros, set the per-source enable masks and choose the edge polarity of each pin. The core supplies a global disable flag, which suppresses the interrupt line without changing any stored state. When the core services the interrupt it pulses an acknowledge, and this retires the request of the source being reported.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every request, enable and edge-select bit is 0, so both pins detect falling edges. All registers read back 0 and `irq_o` is low.
- R2: The registers are fully decoded at request-low 0x03C (sources 0..7 on bits 0..7), request-high 0x03D (sources 8..14 on bits 0..6), enable-low 0x03E, enable-high 0x03F and edge-select 0xFF3. Any other address reads 0, and a write to it changes nothing.
- R3: When `evt_i[k]` is high during a clock edge, request bit k reads 1 from that edge on. `evt_i[4]` and `evt_i[8]` are ignored, because those two sources belong to the pins.
- R4: Writing a 0 to a request bit clears it. Writing a 1 leaves it unchanged, so software can never set a request.
- R5: If a hardware event and a software clear reach the same request bit on the same edge, the bit ends up set.
- R6: Bit 7 of request-high and bit 7 of enable-high ignore writes and always read 0.
- R7: Pin 0 feeds source 4 and pin 1 feeds source 8. Edge-select bit 0 controls pin 0 and bit 1 controls pin 1. A value of 0 selects falling-edge detection and 1 selects rising-edge detection. Bits 7..2 of edge-select read 0. A pin change made between two edges sets its request on the third following edge.
- R8: `irq_o` is high exactly when at least one source has both its request and enable bits set and `gdis_i` is low.
- R9: While `irq_o` is high, `irq_id_o` is the lowest source index that has both its request and enable bits set.
- R10: `ack_i` high while `irq_o` is high clears the request of the source shown on `irq_id_o`. `ack_i` high while `irq_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| evt_i | input | 15 | Peripheral event pulses, one bit per source |
| ext_pin_i | input | 2 | Asynchronous external interrupt pins |
| gdis_i | input | 1 | Global interrupt-disable flag from the core |
| ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | 4 | Index of the source being requested |

## Verification
The assertions assume that `gdis_i`, `ack_i`, the event pulses and the bus signals are synchronous to `clk`. Only the two pins are allowed to change freely. They also assume that a source's request is kept for only as long as software or the acknowledge leaves it alone. The bench therefore changes every input, pins included, only on the falling clock edge. It pulses events, writes and acknowledges for exactly one cycle. It drives the acknowledge both while an interrupt is pending and while none is.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 8;
  localparam int NSRC    = 15;
  localparam int N_PIN   = 2;
  localparam int ID_W    = $clog2(NSRC);
  localparam int HI_W    = NSRC - DATA_W;

  localparam logic [ADDR_W-1:0] A_REQ_LO = 12'h03C;
  localparam logic [ADDR_W-1:0] A_REQ_HI = 12'h03D;
  localparam logic [ADDR_W-1:0] A_EN_LO  = 12'h03E;
  localparam logic [ADDR_W-1:0] A_EN_HI  = 12'h03F;
  localparam logic [ADDR_W-1:0] A_EDGE   = 12'hFF3;

  localparam int PIN0_SRC = 4;
  localparam int PIN1_SRC = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_REQ_LO, SEL_REQ_HI, SEL_EN_LO, SEL_EN_HI, SEL_EDGE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      A_REQ_LO: return SEL_REQ_LO;
      A_REQ_HI: return SEL_REQ_HI;
      A_EN_LO:  return SEL_EN_LO;
      A_EN_HI:  return SEL_EN_HI;
      A_EDGE:   return SEL_EDGE;
      default:  return SEL_NONE;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] pin_mask();
    logic [NSRC-1:0] m;
    m = '0;
    m[PIN0_SRC] = 1'b1;
    m[PIN1_SRC] = 1'b1;
    return m;
  endfunction

  function automatic logic [ID_W-1:0] lowest_set(input logic [NSRC-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = ID_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int N_PIN  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_i,
  input  logic [N_PIN-1:0] rise_sel_i,
  output logic [N_PIN-1:0] edge_o
);
  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic [STAGES:0] sh_q;
    logic cur, prv;
    always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin_i[g]};
    end
    assign cur = sh_q[STAGES-1];
    assign prv = sh_q[STAGES];
    assign edge_o[g] = rise_sel_i[g] ? (cur & ~prv) : (~cur & prv);
  end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int NSRC = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] req_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) req_o <= '0;
    else        req_o <= (req_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  output logic            any_o,
  output logic [ID_W-1:0] id_o
);
  assign any_o = |pend_i;
  assign id_o  = lowest_set(pend_i);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [N_PIN-1:0]  ext_pin_i,
  input  logic              gdis_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [ID_W-1:0]   irq_id_o
);
  localparam logic [NSRC-1:0] PIN_SRCS = pin_mask();

  reg_sel_e          sel;
  logic [NSRC-1:0]   req_q, en_q, hw_set, sw_clr, ack_clr, pend;
  logic [N_PIN-1:0]  edge_q, pin_edge;
  logic              pend_any;
  logic              ack_take;

  assign sel = decode(bus_addr);

  irq_pin_edge #(.N_PIN(N_PIN), .STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i),
    .rise_sel_i(edge_q), .edge_o(pin_edge)
  );

  always_comb begin
    hw_set = evt_i & ~PIN_SRCS;
    hw_set[PIN0_SRC] = pin_edge[0];
    hw_set[PIN1_SRC] = pin_edge[1];
  end

  always_comb begin
    sw_clr = '0;
    if (bus_we && sel == SEL_REQ_LO) sw_clr[DATA_W-1:0] = ~bus_wdata;
    if (bus_we && sel == SEL_REQ_HI) sw_clr[NSRC-1:DATA_W] = ~bus_wdata[HI_W-1:0];
  end

  assign ack_take = ack_i && irq_o;
  assign ack_clr  = ack_take ? (NSRC'(1) << irq_id_o) : '0;

  irq_req_bank #(.NSRC(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .set_i(hw_set),
    .clr_i(sw_clr | ack_clr), .req_o(req_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      edge_q <= '0;
    end else if (bus_we) begin
      if (sel == SEL_EN_LO) en_q[DATA_W-1:0]    <= bus_wdata;
      if (sel == SEL_EN_HI) en_q[NSRC-1:DATA_W] <= bus_wdata[HI_W-1:0];
      if (sel == SEL_EDGE)  edge_q              <= bus_wdata[N_PIN-1:0];
    end
  end

  assign pend = req_q & en_q;

  irq_prio u_prio (.pend_i(pend), .any_o(pend_any), .id_o(irq_id_o));

  assign irq_o = pend_any && !gdis_i;

  always_comb begin
    case (sel)
      SEL_REQ_LO: bus_rdata = req_q[DATA_W-1:0];
      SEL_REQ_HI: bus_rdata = DATA_W'(req_q[NSRC-1:DATA_W]);
      SEL_EN_LO:  bus_rdata = en_q[DATA_W-1:0];
      SEL_EN_HI:  bus_rdata = DATA_W'(en_q[NSRC-1:DATA_W]);
      SEL_EDGE:   bus_rdata = DATA_W'(edge_q);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   req,
  input logic [NSRC-1:0]   en,
  input logic [NSRC-1:0]   hw_set,
  input logic              gdis,
  input logic              irq,
  input logic [ID_W-1:0]   id,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata
);
  logic [NSRC-1:0] pend, below;
  assign pend  = req & en;
  assign below = (NSRC'(1) << id) - NSRC'(1);

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((req & $past(hw_set)) == $past(hw_set))); // R5
  AST_NO_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((req & ~$past(req) & ~$past(hw_set)) == '0)); // R4
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!gdis && pend != '0)); // R8
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (!gdis && pend != '0) |-> irq); // R8
  AST_ID_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend[id] && (pend & below) == '0)); // R9
  AST_EDGE_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_EDGE) |-> (rdata[DATA_W-1:N_PIN] == '0)); // R7
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_REQ_HI || addr == A_EN_HI) |-> !rdata[DATA_W-1]); // R6
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req_q), .en(en_q), .hw_set(hw_set),
  .gdis(gdis_i), .irq(irq_o), .id(irq_id_o), .addr(bus_addr), .rdata(bus_rdata)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic [7:0]  rdata;
  logic [14:0] evt = '0;
  logic [1:0]  pin = '0;
  logic        gdis = 1'b0;
  logic        ack = 1'b0;
  logic        irq;
  logic [3:0]  id;

  int n_chk = 0;
  int n_err = 0;

  // reference state
  logic [14:0] m_req = '0, m_en = '0;
  logic [1:0]  m_edge = '0;
  logic [2:0]  m_hist [2];

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_rdata(rdata), .evt_i(evt), .ext_pin_i(pin), .gdis_i(gdis),
    .ack_i(ack), .irq_o(irq), .irq_id_o(id)
  );

  always #4ns clk = ~clk;

  initial begin
    m_hist[0] = '0;
    m_hist[1] = '0;
  end

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_pick();
    for (int i = 0; i < 15; i++) if (m_req[i] && m_en[i]) return i;
    return -1;
  endfunction

  function automatic int m_read(input logic [11:0] a);
    case (a)
      12'h03C: return int'(m_req[7:0]);
      12'h03D: return int'(m_req[14:8]);
      12'h03E: return int'(m_en[7:0]);
      12'h03F: return int'(m_en[14:8]);
      12'hFF3: return int'(m_edge);
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    logic [14:0] nxt, hw;
    int w;
    if (!rst_n) begin
      m_req = '0; m_en = '0; m_edge = '0;
      m_hist[0] = '0; m_hist[1] = '0;
      return;
    end
    w = m_pick();
    hw = evt;
    hw[4] = 1'b0;
    hw[8] = 1'b0;
    for (int p = 0; p < 2; p++) begin
      logic c, v, d;
      c = m_hist[p][1];
      v = m_hist[p][2];
      d = m_edge[p] ? (c && !v) : (!c && v);
      if (d) hw[p == 0 ? 4 : 8] = 1'b1;
      m_hist[p] = {m_hist[p][1:0], pin[p]};
    end
    nxt = m_req;
    if (we && addr == 12'h03C) for (int i = 0; i < 8; i++) if (!wdata[i]) nxt[i] = 1'b0;
    if (we && addr == 12'h03D) for (int i = 0; i < 7; i++) if (!wdata[i]) nxt[8+i] = 1'b0;
    if (ack && !gdis && w >= 0) nxt[w] = 1'b0;
    m_req = nxt | hw;
    if (we && addr == 12'h03E) m_en[7:0] = wdata;
    if (we && addr == 12'h03F) m_en[14:8] = wdata[6:0];
    if (we && addr == 12'hFF3) m_edge = wdata[1:0];
  endtask

  task automatic tick();
    int w;
    @(posedge clk);
    model_step();
    @(negedge clk);
    w = m_pick();
    check(int'(irq), int'(w >= 0 && !gdis), "R8 irq line");
    if (w >= 0 && !gdis) check(int'(id), w, "R9 source index");
    we = 1'b0; evt = '0; ack = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
  endtask

  task automatic rd(input logic [11:0] a, input int exp, input string tag);
    addr = a; we = 1'b0;
    #1ns;
    check(int'(rdata), exp, tag);
    check(int'(rdata), m_read(a), tag);
  endtask

  initial begin
    #1ms;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(12'h03C, 0, "R1"); rd(12'h03D, 0, "R1"); rd(12'h03E, 0, "R1");
    rd(12'h03F, 0, "R1"); rd(12'hFF3, 0, "R1");
    check(int'(irq), 0, "R1 irq low");

    // R3 event latching, pin-owned bits ignored
    evt = 15'h0004; tick(); rd(12'h03C, 8'h04, "R3");
    evt = 15'h0010; tick(); rd(12'h03C, 8'h04, "R3 bit4 ignored");
    evt = 15'h0100; tick(); rd(12'h03D, 8'h00, "R3 bit8 ignored");

    // R4 software clear only
    wr(12'h03C, 8'hFF); rd(12'h03C, 8'h04, "R4 write one");
    wr(12'h03C, 8'hFB); rd(12'h03C, 8'h00, "R4 write zero");

    // R5 event beats clear
    evt = 15'h0008; addr = 12'h03C; wdata = 8'h00; we = 1'b1; tick();
    rd(12'h03C, 8'h08, "R5");
    wr(12'h03C, 8'h00); rd(12'h03C, 8'h00, "R5 cleared");

    // R6 unimplemented top bits
    wr(12'h03F, 8'hFF); rd(12'h03F, 8'h7F, "R6 enable top");
    wr(12'h03F, 8'h00);
    evt = 15'h7F00; tick(); rd(12'h03D, 8'h7E, "R6 request top");
    wr(12'h03D, 8'hFF); rd(12'h03D, 8'h7E, "R6 write ones");
    wr(12'h03D, 8'h00); rd(12'h03D, 8'h00, "R6 cleared");

    // R8 / R9 masking and priority
    wr(12'h03E, 8'h24);
    wr(12'h03F, 8'h12);
    evt = 15'h1222; tick();
    check(int'(irq), 1, "R8 raised");
    check(int'(id), 5, "R9 lowest wins");
    gdis = 1'b1; #1ns; check(int'(irq), 0, "R8 global disable");
    tick(); gdis = 1'b0; #1ns; check(int'(irq), 1, "R8 re-enabled");

    // R10 acknowledge
    ack = 1'b1; tick(); check(int'(id), 9, "R10 next source");
    rd(12'h03C, 8'h02, "R10 source 5 retired");
    ack = 1'b1; tick(); check(int'(id), 12, "R10 next source");
    ack = 1'b1; tick(); check(int'(irq), 0, "R10 all retired");
    evt = 15'h0080; tick();
    ack = 1'b1; tick(); rd(12'h03C, 8'h82, "R10 ack without irq");
    wr(12'h03C, 8'h00);

    // R7 pins and polarity
    pin[0] = 1'b1; repeat (4) tick();
    rd(12'h03C, 8'h00, "R7 rise ignored when falling");
    pin[0] = 1'b0; tick(); tick();
    rd(12'h03C, 8'h00, "R7 not before third edge");
    tick(); rd(12'h03C, 8'h10, "R7 falling edge");
    wr(12'hFF3, 8'hFF); rd(12'hFF3, 8'h03, "R7 edge select");
    pin[1] = 1'b1; repeat (3) tick();
    rd(12'h03D, 8'h01, "R7 pin1 rising");
    wr(12'h03C, 8'h00);
    pin[0] = 1'b1; repeat (3) tick();
    rd(12'h03C, 8'h10, "R7 pin0 rising");
    pin[0] = 1'b0; repeat (4) tick();
    wr(12'h03C, 8'h00); rd(12'h03C, 8'h00, "R7 fall ignored when rising");

    // R2 full decode
    wr(12'h040, 8'hFF); rd(12'h040, 0, "R2 unmapped");
    evt = 15'h0001; tick();
    wr(12'h13C, 8'h00); rd(12'h03C, 8'h01, "R2 no alias");
    wr(12'h03C, 8'h00); rd(12'h03C, 8'h00, "R2 mapped");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule